// File: doc/BRIEF.md
# Serial Polynomial Division Signature Analyzer

This block compacts a serial response stream into a five-bit signature by dividing the stream, taken as a polynomial over GF(2), by the fixed divisor G(x) = x^5 + x^3 + x + 1. It is built as a five-stage shift register with the feedback XOR gates placed inside the chain. The most significant coefficient of the stream enters first, one bit per qualified clock. After the last bit, the register holds the remainder of the division. The bit pushed out of the top stage on each shift is a quotient coefficient, and the block presents it with its own strobe.

A test controller clears the register synchronously, then streams the response bits with a valid flag, then reads the signature. A comparator raises a match flag whenever the register equals a golden signature fixed by a parameter. As with any polynomial compactor, streams that differ from the good one by a multiple of G(x) alias to the same signature.

Top module: `sig_divider`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and on its release, the signature is 0 and the quotient strobe is low.
- R2: When the clear input is high at a clock edge, the signature becomes 0 and the quotient strobe is low in the next cycle, even if the bit-valid input is also high.
- R3: When clear and bit-valid are both low at a clock edge, the signature keeps its value and the quotient strobe is low in the next cycle.
- R4: A valid, uncleared edge updates the signature (bit i is the coefficient of x^i) as follows, with q = old bit 4: new bit0 = data ^ q, new bit1 = bit0 ^ q, new bit2 = bit1, new bit3 = bit2 ^ q, new bit4 = bit3.
- R5: After each valid, uncleared edge, the quotient strobe is high for one cycle and the quotient bit equals the old bit 4 of the signature.
- R6: From a cleared state, the stream 1,0,0,0,1,0,1,0 (x^7+x^3+x, first bit first) leaves the signature 5'b01101 (x^3+x^2+1). The quotient bits read 0,0,0,0,0,1,0,1 in order, which is Q(x) = x^2+1.
- R7: The streams 1,0,1,0,0,0,0,1 (P+G) and 1,1,0,1,1,1,0,0 (P+x*G) also leave 5'b01101.
- R8: The match output is high exactly when the signature equals the golden parameter, which defaults to 5'b01101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear; takes priority over bitValid |
| bitValid | input | 1 | Shift in bitIn on this edge |
| bitIn | input | 1 | Serial stream bit, highest order first |
| signature | output | 5 | Current remainder, bit i = coefficient of x^i |
| quoBit | output | 1 | Quotient bit shifted out by the last valid edge |
| quoValid | output | 1 | quoBit is fresh this cycle |
| match | output | 1 | signature equals the golden value |

## Verification
The bench targets the edge case where clear and bit-valid are high together. A design that got the priority wrong would shift a bit in, leave a nonzero signature and raise the quotient strobe. Idle cycles between bits are checked as well: a design that ignored bit-valid would keep dividing and drift from the model. The known division and its two aliasing streams catch feedback taps in the wrong positions, a reversed bit order, or a quotient taken from the wrong stage. Each of these faults changes the remainder away from 5'b01101 or changes the quotient from 00000101.

// File: rtl/sig_divider_pkg.sv
package sig_divider_pkg;
  // Degree of the divisor and the feedback taps (x^3 + x + 1 terms)
  localparam int SigWidth = 5;
  localparam logic [SigWidth-1:0] SigTaps = 5'b01011;
  localparam logic [SigWidth-1:0] SigGolden = 5'b01101;

  typedef struct packed {
    logic clrStb;
    logic shiftStb;
  } sigCtrl_t;
endpackage

// File: rtl/sig_divider_ctrl.sv
module sig_divider_ctrl
  import sig_divider_pkg::*;
(
  input  logic     clear,
  input  logic     bitValid,
  output sigCtrl_t ctrl
);
  // Clear wins over a shift request
  always_comb begin
    ctrl.clrStb   = clear;
    ctrl.shiftStb = bitValid & ~clear;
  end
endmodule

// File: rtl/sig_divider_dp.sv
module sig_divider_dp
  import sig_divider_pkg::*;
#(
  parameter int W = SigWidth,
  parameter logic [W-1:0] TAPS = SigTaps
) (
  input  logic         clk,
  input  logic         rst_n,
  input  sigCtrl_t     ctrl,
  input  logic         bitIn,
  output logic [W-1:0] state,
  output logic         quoBit,
  output logic         quoValid
);
  localparam int TopIdx = W - 1;

  logic [W-1:0] nextState;
  logic         topBit;

  assign topBit = state[TopIdx];

  // Each stage takes its lower neighbour (or the input) plus the tap term
  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign nextState[i] = bitIn ^ (TAPS[i] & topBit);
    end else begin : g_rest
      assign nextState[i] = state[i-1] ^ (TAPS[i] & topBit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= '0;
      quoBit   <= 1'b0;
      quoValid <= 1'b0;
    end else if (ctrl.clrStb) begin
      state    <= '0;
      quoBit   <= 1'b0;
      quoValid <= 1'b0;
    end else if (ctrl.shiftStb) begin
      state    <= nextState;
      quoBit   <= topBit;
      quoValid <= 1'b1;
    end else begin
      quoValid <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_divider.sv
module sig_divider
  import sig_divider_pkg::*;
#(
  parameter int W = SigWidth,
  parameter logic [W-1:0] TAPS = SigTaps,
  parameter logic [W-1:0] GOLDEN = SigGolden
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         bitValid,
  input  logic         bitIn,
  output logic [W-1:0] signature,
  output logic         quoBit,
  output logic         quoValid,
  output logic         match
);
  sigCtrl_t ctrl;

  sig_divider_ctrl ctrl_i (
    .clear   (clear),
    .bitValid(bitValid),
    .ctrl    (ctrl)
  );

  sig_divider_dp #(.W(W), .TAPS(TAPS)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .bitIn   (bitIn),
    .state   (signature),
    .quoBit  (quoBit),
    .quoValid(quoValid)
  );

  assign match = (signature == GOLDEN);
endmodule

// File: rtl/sig_divider_chk.sv
module sig_divider_chk #(
  parameter int W = 5,
  parameter logic [W-1:0] TAPS = 5'b01011,
  parameter logic [W-1:0] GOLDEN = 5'b01101
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         bitValid,
  input logic         bitIn,
  input logic [W-1:0] signature,
  input logic         quoBit,
  input logic         quoValid,
  input logic         match
);
  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (signature == '0) && !quoValid);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !bitValid) |=> $stable(signature) && !quoValid);

  // R5
  quo_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && bitValid) |=> quoValid && (quoBit == $past(signature[W-1])));

  // R4
  shift_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && bitValid) |=> signature ==
      ({$past(signature[W-2:0]), $past(bitIn)} ^ ($past(signature[W-1]) ? TAPS : '0)));

  // R8
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match == (signature == GOLDEN));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (signature == '0) && !quoValid);
endmodule

bind sig_divider sig_divider_chk #(.W(W), .TAPS(TAPS), .GOLDEN(GOLDEN)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .bitValid (bitValid),
  .bitIn    (bitIn),
  .signature(signature),
  .quoBit   (quoBit),
  .quoValid (quoValid),
  .match    (match)
);

// File: tb/sig_divider_tb_top.sv
`timescale 1ns/1ps
module sig_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       bitValid = 1'b0;
  logic       bitIn = 1'b0;
  logic [4:0] signature;
  logic       quoBit;
  logic       quoValid;
  logic       match;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [4:0] modelSig = '0;
  logic [5:0] expQ[$];      // {quotient bit, signature after shift}
  logic [7:0] quoHist = '0;

  always #5 clk = ~clk;

  sig_divider dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .bitValid(bitValid), .bitIn(bitIn),
    .signature(signature), .quoBit(quoBit), .quoValid(quoValid), .match(match)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Division rule from R4: taps at x0, x1, x3
  function automatic logic [4:0] stepSig(input logic [4:0] s, input logic b);
    logic q;
    q = s[4];
    return {s[3], s[2] ^ q, s[1], s[0] ^ q, b ^ q};
  endfunction

  task automatic sendBit(input logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitIn    = b;
    expQ.push_back({modelSig[4], stepSig(modelSig, b)});
    modelSig = stepSig(modelSig, b);
  endtask

  task automatic idle();
    @(negedge clk);
    bitValid = 1'b0;
    bitIn    = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    clear    = 1'b1;
    bitValid = 1'b1;   // R2: shift request must lose to clear
    bitIn    = 1'b1;
    @(negedge clk);
    clear    = 1'b0;
    bitValid = 1'b0;
    modelSig = '0;
    check("R2 clear signature", {3'b0, signature}, 8'h00);
    check("R2 clear quoValid", {7'b0, quoValid}, 8'h00);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    idle();
  endtask

  // Monitor: pops the scoreboard on every quotient strobe
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && quoValid) begin
        quoHist = {quoHist[6:0], quoBit};
        if (expQ.size() == 0) begin
          check("R5 unexpected quotient strobe", 8'h01, 8'h00);
        end else begin
          logic [5:0] e;
          e = expQ.pop_front();
          check("R5 quotient bit", {7'b0, quoBit}, {7'b0, e[5]});
          check("R4 signature step", {3'b0, signature}, {3'b0, e[4:0]});
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset signature", {3'b0, signature}, 8'h00);
    check("R1 reset quoValid", {7'b0, quoValid}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release signature", {3'b0, signature}, 8'h00);
    check("R8 no match at zero", {7'b0, match}, 8'h00);

    // R6: known division
    quoHist = '0;
    sendByte(8'b10001010);
    check("R6 remainder", {3'b0, signature}, 8'h0D);
    check("R6 quotient stream", quoHist, 8'b00000101);
    check("R8 match on golden", {7'b0, match}, 8'h01);

    // R3: idle cycles hold
    repeat (4) idle();
    check("R3 hold signature", {3'b0, signature}, 8'h0D);
    check("R3 no strobe while idle", {7'b0, quoValid}, 8'h00);

    // R7: aliasing streams
    doClear();
    sendByte(8'b10100001);
    check("R7 P+G signature", {3'b0, signature}, 8'h0D);
    doClear();
    sendByte(8'b11011100);
    check("R7 P+xG signature", {3'b0, signature}, 8'h0D);

    // R3/R4: stream with gaps
    doClear();
    for (int i = 0; i < 12; i++) begin
      sendBit(i[0] ^ i[2]);
      if (i % 3 == 0) idle();
    end
    idle();
    check("R3 gapped stream", {3'b0, signature}, {3'b0, modelSig});
    check("R8 match tracks signature", {7'b0, match}, {7'b0, modelSig == 5'h0D});

    // R2: clear in the middle of a stream
    sendBit(1'b1); sendBit(1'b1);
    doClear();

    // R4/R5: pseudo-random streams
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 20; i++) sendBit(1'($urandom_range(0, 1)));
      idle();
      check("R4 random stream", {3'b0, signature}, {3'b0, modelSig});
      doClear();
    end

    // all-ones stream exercises feedback every step
    for (int i = 0; i < 10; i++) sendBit(1'b1);
    idle();
    check("R4 all ones", {3'b0, signature}, {3'b0, modelSig});

    repeat (3) idle();
    check("R5 scoreboard drained", {2'b0, 6'(expQ.size())}, 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule